// File: doc/BRIEF.md
# Channel Program Command Executor

This block is an I/O coprocessor that sits between the CPU, main memory and one device controller. The CPU starts it with a start-I/O that names a device and the memory address of a command program. From then on, the block fetches two-word commands from memory on its own and carries them out against the device. A command can position the device, move data from the device into a memory buffer, move data from a memory buffer to the device, branch to another command, or end the program. The CPU is not involved until the block interrupts it.

Every command can ask for a progress interrupt when it completes, and the end of a program always raises one. The CPU reads busy, done, error and interrupt-pending through a test-I/O. The test-I/O also acknowledges the pending interrupt. Memory is a single word-addressed port with a read latency of one cycle. The device side uses three valid/ready handshakes: one for positioning, one for inbound words and one for outbound words.

Top module: `chan_exec`

## Requirements
- R1: After reset, `irq`, `sio_ok`, `sio_rej` and `tio_valid` are low and no memory access is issued. A test-I/O returns a status of 0.
- R2: A start request while idle gives a one-cycle `sio_ok` in the next cycle. It sets busy, clears done and error, and the first memory read is at the program address given in `sio_addr`.
- R3: A start request while a program runs gives a one-cycle `sio_rej` in the next cycle and no `sio_ok`. The running program continues unchanged, and the rejected address is never fetched.
- R4: A command is two words: word A at P and word B at P+1. Word A holds opcode [31:28], interrupt flag [27], reserved bits [26:16] and byte count [15:0]. The next command is fetched from P+2.
- R5: Opcode 1 (position) holds `dev_seek_valid` with cylinder = B[31:16], head = B[15:8] and record = B[7:0] until `dev_seek_ack`. `dev_sel` shows the device named at start.
- R6: Opcode 2 (device to memory) takes ceil(count/4) words from the inbound handshake. It writes them to consecutive addresses starting at buffer address B, and writes memory at no other time.
- R7: Opcode 3 (memory to device) reads ceil(count/4) words from consecutive addresses starting at B. It presents them in order on the outbound handshake, holding each word until it is accepted.
- R8: A transfer with a count of 0 moves no word and completes at once.
- R9: Opcode 4 (branch) makes the next fetch come from address B.
- R10: Opcode 0 (end) clears busy, sets done and raises `irq`.
- R11: A command with its interrupt flag set raises `irq` when it completes, while the program keeps running.
- R12: An opcode above 4, or nonzero reserved bits, stops the program. It clears busy, sets error and done, and raises `irq`.
- R13: A test-I/O gives `tio_valid` in the next cycle with status {irq [3], error [2], done [1], busy [0]} as it was when requested, and clears the pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sio_req | input | 1 | Start-I/O request pulse |
| sio_dev | input | DEV_W | Device address for the start |
| sio_addr | input | AW | Word address of the first command |
| sio_ok | output | 1 | Start accepted (one cycle) |
| sio_rej | output | 1 | Start rejected, channel busy (one cycle) |
| tio_req | input | 1 | Test-I/O request pulse |
| tio_valid | output | 1 | Test-I/O response strobe |
| tio_status | output | 4 | {irq, error, done, busy} |
| irq | output | 1 | Interrupt pending to the CPU |
| mem_rd_en | output | 1 | Memory read, data next cycle |
| mem_wr_en | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| dev_sel | output | DEV_W | Device being driven |
| dev_seek_valid | output | 1 | Positioning request |
| dev_seek_ack | input | 1 | Positioning complete |
| dev_cyl | output | 16 | Cylinder field |
| dev_head | output | 8 | Head field |
| dev_rec | output | 8 | Record field |
| dev_rx_ready | output | 1 | Channel can take an inbound word |
| dev_rx_valid | input | 1 | Device offers an inbound word |
| dev_rx_data | input | 32 | Inbound word |
| dev_tx_valid | output | 1 | Outbound word offered |
| dev_tx_ready | input | 1 | Device takes the outbound word |
| dev_tx_data | output | 32 | Outbound word |

## Verification
A wrong program counter or decode shows within a few cycles: the memory read address sequence goes off the P, P+1, P+2 chain, or a branch target is not fetched. A wrong word counter shows when the transfer ends, as one word too many or too few written to memory past the buffer, or presented to the device. A wrong status register shows at the next test-I/O and on `irq`. This includes a lost acknowledge, a rejected start that disturbs a running program, or an error bit left set by an earlier illegal command.

// File: rtl/chx_pkg.sv
package chx_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam int WC_W   = CNT_W - 1;

    typedef enum logic [3:0] {
        OP_END   = 4'd0,
        OP_SEEK  = 4'd1,
        OP_READ  = 4'd2,
        OP_WRITE = 4'd3,
        OP_TIC   = 4'd4
    } chx_op_e;

    typedef struct packed {
        logic [3:0]        op;
        logic              legal;
        logic              intr;
        logic [CNT_W-1:0]  count;
        logic [WORD_W-1:0] arg;
    } chx_cmd_t;

    typedef struct packed {
        logic irq;
        logic err;
        logic done;
        logic busy;
    } chx_stat_t;

    typedef enum logic [2:0] {
        S_IDLE, S_F0, S_F1, S_F2, S_EXEC, S_SEEK, S_XFER
    } chx_seq_e;

    typedef enum logic [2:0] {
        X_IDLE, X_RX, X_TXF, X_TXW, X_TXH
    } chx_xs_e;

    function automatic logic [WC_W-1:0] words_of(input logic [CNT_W-1:0] count);
        logic [CNT_W:0] t;
        t = {1'b0, count} + (CNT_W+1)'(3);
        return t[CNT_W:2];
    endfunction

    function automatic logic op_known(input logic [3:0] op);
        return op <= 4'(OP_TIC);
    endfunction

endpackage

// File: rtl/chx_cmd_decode.sv
module chx_cmd_decode
    import chx_pkg::*;
(
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output chx_cmd_t          cmd
);
    always_comb begin
        cmd.op    = word_a[31:28];
        cmd.intr  = word_a[27];
        cmd.count = word_a[CNT_W-1:0];
        cmd.arg   = word_b;
        cmd.legal = op_known(word_a[31:28]) && (word_a[26:16] == 11'd0);
    end
endmodule

// File: rtl/chx_xfer.sv
module chx_xfer
    import chx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              to_mem,
    input  logic [AW-1:0]     buf_addr,
    input  logic [CNT_W-1:0]  count,
    output logic              done,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rx_ready,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [WORD_W-1:0] tx_data
);
    chx_xs_e           st;
    logic [AW-1:0]     addr;
    logic [WC_W-1:0]   left;
    logic [WORD_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= X_IDLE;
            addr <= '0;
            left <= '0;
            hold <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                X_IDLE: begin
                    if (start) begin
                        addr <= buf_addr;
                        left <= words_of(count);
                        st   <= to_mem ? X_RX : X_TXF;
                    end
                end
                X_RX: begin
                    if (rx_valid) begin
                        addr <= addr + AW'(1);
                        left <= left - WC_W'(1);
                        if (left == WC_W'(1)) begin
                            st   <= X_IDLE;
                            done <= 1'b1;
                        end
                    end
                end
                X_TXF: st <= X_TXW;
                X_TXW: begin
                    hold <= mem_rdata;
                    st   <= X_TXH;
                end
                X_TXH: begin
                    if (tx_ready) begin
                        addr <= addr + AW'(1);
                        left <= left - WC_W'(1);
                        if (left == WC_W'(1)) begin
                            st   <= X_IDLE;
                            done <= 1'b1;
                        end else begin
                            st <= X_TXF;
                        end
                    end
                end
                default: st <= X_IDLE;
            endcase
        end
    end

    always_comb begin
        rx_ready  = (st == X_RX);
        mem_wr_en = (st == X_RX) && rx_valid;
        mem_rd_en = (st == X_TXF);
        mem_addr  = addr;
        mem_wdata = rx_data;
        tx_valid  = (st == X_TXH);
        tx_data   = hold;
    end
endmodule

// File: rtl/chx_stat.sv
module chx_stat
    import chx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sio_req,
    input  logic      tio_req,
    input  logic      ev_prog,
    input  logic      ev_end,
    input  logic      ev_err,
    output logic      accept,
    output logic      sio_ok,
    output logic      sio_rej,
    output logic      tio_valid,
    output logic [3:0] tio_status,
    output logic      irq
);
    chx_stat_t cur, nxt;

    assign accept = sio_req && !cur.busy;
    assign irq    = cur.irq;

    always_comb begin
        nxt = cur;
        if (tio_req) nxt.irq = 1'b0;
        if (accept) begin
            nxt.busy = 1'b1;
            nxt.done = 1'b0;
            nxt.err  = 1'b0;
        end
        if (ev_prog) nxt.irq = 1'b1;
        if (ev_end) begin
            nxt.busy = 1'b0;
            nxt.done = 1'b1;
            nxt.irq  = 1'b1;
        end
        if (ev_err) begin
            nxt.busy = 1'b0;
            nxt.done = 1'b1;
            nxt.err  = 1'b1;
            nxt.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= '0;
            sio_ok     <= 1'b0;
            sio_rej    <= 1'b0;
            tio_valid  <= 1'b0;
            tio_status <= '0;
        end else begin
            cur       <= nxt;
            sio_ok    <= accept;
            sio_rej   <= sio_req && cur.busy;
            tio_valid <= tio_req;
            if (tio_req) tio_status <= cur;
        end
    end
endmodule

// File: rtl/chan_exec.sv
module chan_exec
    import chx_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sio_req,
    input  logic [DEV_W-1:0]  sio_dev,
    input  logic [AW-1:0]     sio_addr,
    output logic              sio_ok,
    output logic              sio_rej,
    input  logic              tio_req,
    output logic              tio_valid,
    output logic [3:0]        tio_status,
    output logic              irq,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [DEV_W-1:0]  dev_sel,
    output logic              dev_seek_valid,
    input  logic              dev_seek_ack,
    output logic [15:0]       dev_cyl,
    output logic [7:0]        dev_head,
    output logic [7:0]        dev_rec,
    output logic              dev_rx_ready,
    input  logic              dev_rx_valid,
    input  logic [31:0]       dev_rx_data,
    output logic              dev_tx_valid,
    input  logic              dev_tx_ready,
    output logic [31:0]       dev_tx_data
);
    chx_seq_e          st;
    logic [AW-1:0]     pc;
    logic [WORD_W-1:0] w_a, w_b;
    logic [DEV_W-1:0]  dev_q;
    chx_cmd_t          cmd;

    logic              accept, ev_prog, ev_end, ev_err, cmd_done;
    logic              seq_rd, x_start, x_done;
    logic [AW-1:0]     seq_addr;
    logic              x_rd, x_wr;
    logic [AW-1:0]     x_addr;
    logic [WORD_W-1:0] x_wdata;

    chx_cmd_decode u_dec (
        .word_a (w_a),
        .word_b (w_b),
        .cmd    (cmd)
    );

    chx_stat u_stat (
        .clk        (clk),
        .rst        (rst),
        .sio_req    (sio_req),
        .tio_req    (tio_req),
        .ev_prog    (ev_prog),
        .ev_end     (ev_end),
        .ev_err     (ev_err),
        .accept     (accept),
        .sio_ok     (sio_ok),
        .sio_rej    (sio_rej),
        .tio_valid  (tio_valid),
        .tio_status (tio_status),
        .irq        (irq)
    );

    chx_xfer #(.AW(AW)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .start     (x_start),
        .to_mem    (cmd.op == 4'(OP_READ)),
        .buf_addr  (cmd.arg[AW-1:0]),
        .count     (cmd.count),
        .done      (x_done),
        .mem_rd_en (x_rd),
        .mem_wr_en (x_wr),
        .mem_addr  (x_addr),
        .mem_wdata (x_wdata),
        .mem_rdata (mem_rdata),
        .rx_ready  (dev_rx_ready),
        .rx_valid  (dev_rx_valid),
        .rx_data   (dev_rx_data),
        .tx_valid  (dev_tx_valid),
        .tx_ready  (dev_tx_ready),
        .tx_data   (dev_tx_data)
    );

    // Per-state strobes of the command sequencer.
    always_comb begin
        seq_rd   = 1'b0;
        seq_addr = pc;
        x_start  = 1'b0;
        ev_prog  = 1'b0;
        ev_end   = 1'b0;
        ev_err   = 1'b0;
        cmd_done = 1'b0;
        case (st)
            S_F0: seq_rd = 1'b1;
            S_F1: begin
                seq_rd   = 1'b1;
                seq_addr = pc + AW'(1);
            end
            S_EXEC: begin
                if (!cmd.legal) begin
                    ev_err = 1'b1;
                end else begin
                    case (cmd.op)
                        OP_END:  ev_end = 1'b1;
                        OP_SEEK: ;
                        OP_READ, OP_WRITE: begin
                            if (cmd.count == '0) cmd_done = 1'b1;
                            else                 x_start  = 1'b1;
                        end
                        OP_TIC:  ev_prog = cmd.intr;
                        default: ev_err = 1'b1;
                    endcase
                end
            end
            S_SEEK: cmd_done = dev_seek_ack;
            S_XFER: cmd_done = x_done;
            default: ;
        endcase
        if (cmd_done) ev_prog = cmd.intr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            pc    <= '0;
            w_a   <= '0;
            w_b   <= '0;
            dev_q <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (accept) begin
                        pc    <= sio_addr;
                        dev_q <= sio_dev;
                        st    <= S_F0;
                    end
                end
                S_F0: st <= S_F1;
                S_F1: begin
                    w_a <= mem_rdata;
                    st  <= S_F2;
                end
                S_F2: begin
                    w_b <= mem_rdata;
                    st  <= S_EXEC;
                end
                S_EXEC: begin
                    if (!cmd.legal || cmd.op == 4'(OP_END)) begin
                        st <= S_IDLE;
                    end else if (cmd.op == 4'(OP_SEEK)) begin
                        st <= S_SEEK;
                    end else if (cmd.op == 4'(OP_TIC)) begin
                        pc <= cmd.arg[AW-1:0];
                        st <= S_F0;
                    end else if (cmd_done) begin
                        pc <= pc + AW'(2);
                        st <= S_F0;
                    end else begin
                        st <= S_XFER;
                    end
                end
                S_SEEK, S_XFER: begin
                    if (cmd_done) begin
                        pc <= pc + AW'(2);
                        st <= S_F0;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd_en      = seq_rd | x_rd;
        mem_wr_en      = x_wr;
        mem_addr       = (st == S_XFER) ? x_addr : seq_addr;
        mem_wdata      = x_wdata;
        dev_sel        = dev_q;
        dev_seek_valid = (st == S_SEEK);
        dev_cyl        = cmd.arg[31:16];
        dev_head       = cmd.arg[15:8];
        dev_rec        = cmd.arg[7:0];
    end
endmodule

// File: rtl/chan_exec_chk.sv
module chan_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic        sio_req,
    input logic        sio_ok,
    input logic        sio_rej,
    input logic        tio_req,
    input logic        tio_valid,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic        dev_seek_valid,
    input logic        dev_seek_ack,
    input logic [15:0] dev_cyl,
    input logic [7:0]  dev_head,
    input logic [7:0]  dev_rec,
    input logic        dev_rx_valid,
    input logic        dev_rx_ready,
    input logic        dev_tx_valid,
    input logic        dev_tx_ready,
    input logic [31:0] dev_tx_data
);
    AST_START_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        sio_req |=> (sio_ok || sio_rej)); // R2
    AST_START_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        !(sio_ok && sio_rej)); // R3
    AST_SEEK_HELD: assert property (@(posedge clk) disable iff (rst)
        (dev_seek_valid && !dev_seek_ack) |=>
            (dev_seek_valid && $stable(dev_cyl) && $stable(dev_head) && $stable(dev_rec))); // R5
    AST_WRITE_ON_RX_ONLY: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (dev_rx_valid && dev_rx_ready)); // R6
    AST_SINGLE_MEM_OP: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_en && mem_rd_en)); // R6
    AST_TX_HELD: assert property (@(posedge clk) disable iff (rst)
        (dev_tx_valid && !dev_tx_ready) |=> (dev_tx_valid && $stable(dev_tx_data))); // R7
    AST_TEST_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        tio_req |=> tio_valid); // R13
endmodule

bind chan_exec chan_exec_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .sio_req        (sio_req),
    .sio_ok         (sio_ok),
    .sio_rej        (sio_rej),
    .tio_req        (tio_req),
    .tio_valid      (tio_valid),
    .mem_rd_en      (mem_rd_en),
    .mem_wr_en      (mem_wr_en),
    .dev_seek_valid (dev_seek_valid),
    .dev_seek_ack   (dev_seek_ack),
    .dev_cyl        (dev_cyl),
    .dev_head       (dev_head),
    .dev_rec        (dev_rec),
    .dev_rx_valid   (dev_rx_valid),
    .dev_rx_ready   (dev_rx_ready),
    .dev_tx_valid   (dev_tx_valid),
    .dev_tx_ready   (dev_tx_ready),
    .dev_tx_data    (dev_tx_data)
);

// File: tb/chan_exec_bench.sv
`timescale 1ns/1ps
module chan_exec_bench;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sio_req = 1'b0;
    logic [DW-1:0] sio_dev = '0;
    logic [AW-1:0] sio_addr = '0;
    logic          sio_ok, sio_rej, tio_valid, irq;
    logic          tio_req = 1'b0;
    logic [3:0]    tio_status;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic [DW-1:0] dev_sel;
    logic          dev_seek_valid;
    logic          dev_seek_ack = 1'b0;
    logic [15:0]   dev_cyl;
    logic [7:0]    dev_head, dev_rec;
    logic          dev_rx_ready;
    logic          dev_rx_valid = 1'b1;
    logic [31:0]   dev_rx_data = 32'hA500_0000;
    logic          dev_tx_valid;
    logic          dev_tx_ready = 1'b0;
    logic [31:0]   dev_tx_data;

    always #5 clk = ~clk;

    chan_exec #(.AW(AW), .DEV_W(DW)) u_chan_exec (.*);

    // Models of memory and device
    logic [31:0] mem [256];
    logic [AW-1:0] rd_log [64];
    int rd_n = 0;
    logic [31:0] tx_log [16];
    int tx_n = 0;
    int seek_n = 0;
    logic [31:0] seek_fields = '0;
    logic seek_hold = 1'b0;
    int rx_idx = 0;
    logic rx_hs = 1'b0;

    initial forever begin
        @(posedge clk);
        if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[7:0]];
            if (rd_n < 64) rd_log[rd_n] = mem_addr;
            rd_n++;
        end
    end

    initial forever begin
        @(negedge clk);
        if (rx_hs) rx_idx++;
        dev_rx_data = 32'hA500_0000 + 32'(rx_idx);
        rx_hs = dev_rx_ready && dev_rx_valid;
        dev_seek_ack = dev_seek_valid && !seek_hold;
        if (dev_seek_ack) begin
            seek_n++;
            seek_fields = {dev_cyl, dev_head, dev_rec};
        end
        dev_tx_ready = ~dev_tx_ready;
        if (dev_tx_valid && dev_tx_ready) begin
            if (tx_n < 16) tx_log[tx_n] = dev_tx_data;
            tx_n++;
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd_a(input logic [3:0] op, input logic fl, input logic [15:0] cnt);
        return {op, fl, 11'd0, cnt};
    endfunction

    task automatic do_tio(output logic [3:0] st);
        tio_req = 1'b1;
        @(negedge clk);
        tio_req = 1'b0;
        chk("R13 tio_valid", 32'(tio_valid), 32'd1);
        st = tio_status;
    endtask

    task automatic do_sio(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic ok, output logic rej);
        sio_addr = a;
        sio_dev  = d;
        sio_req  = 1'b1;
        @(negedge clk);
        sio_req = 1'b0;
        ok  = sio_ok;
        rej = sio_rej;
    endtask

    task automatic wait_irq();
        int t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (!irq) begin
            n_chk++;
            n_fail++;
            $display("FAIL wait irq actual=0 expected=1");
        end
    endtask

    // {byte count, expected word count}
    localparam logic [31:0] VEC [6] = '{
        {16'd1,  16'd1}, {16'd4,  16'd1}, {16'd5, 16'd2},
        {16'd8,  16'd2}, {16'd13, 16'd4}, {16'd0, 16'd0}
    };

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] st;
        logic ok, rej;
        int base, words;
        bit found;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 sio_ok", 32'(sio_ok | sio_rej), 32'd0);
        chk("R1 no mem", 32'(rd_n), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        do_tio(st);
        chk("R1 status", 32'(st), 32'd0);

        // Vector table: device-to-memory transfers of several lengths (R6, R8)
        for (int v = 0; v < 6; v++) begin
            words = int'(VEC[v][15:0]);
            for (int j = 0; j < 8; j++) mem[8'h80 + j] = 32'hEEEE_EEEE;
            mem[8'h10] = cmd_a(4'd2, 1'b0, VEC[v][31:16]);
            mem[8'h11] = 32'h0000_0080;
            mem[8'h12] = cmd_a(4'd0, 1'b0, 16'd0);
            mem[8'h13] = 32'h0;
            base = rx_idx;
            do_sio(16'h0010, 8'h11, ok, rej);
            chk("R2 start ok", 32'(ok), 32'd1);
            wait_irq();
            do_tio(st);
            chk("R10 end status", 32'(st), 32'hA);
            for (int j = 0; j < words; j++)
                chk("R6 word", mem[8'h80 + j], 32'hA500_0000 + 32'(base + j));
            chk("R8 no extra word", mem[8'h80 + words], 32'hEEEE_EEEE);
            chk("R6 handshakes", 32'(rx_idx - base), 32'(words));
        end

        // Position, branch, memory-to-device (R2 R4 R5 R9 R7)
        mem[8'h20] = cmd_a(4'd1, 1'b0, 16'd0);
        mem[8'h21] = 32'h0123_4567;
        mem[8'h22] = cmd_a(4'd4, 1'b0, 16'd0);
        mem[8'h23] = 32'h0000_0040;
        mem[8'h24] = 32'hF000_0000;
        mem[8'h40] = cmd_a(4'd3, 1'b0, 16'd9);
        mem[8'h41] = 32'h0000_0090;
        mem[8'h42] = cmd_a(4'd0, 1'b0, 16'd0);
        mem[8'h90] = 32'h1111_0001;
        mem[8'h91] = 32'h2222_0002;
        mem[8'h92] = 32'h3333_0003;
        mem[8'h93] = 32'h4444_0004;
        rd_n = 0;
        tx_n = 0;
        seek_n = 0;
        do_sio(16'h0020, 8'h5C, ok, rej);
        chk("R2 ok", 32'(ok), 32'd1);
        wait_irq();
        chk("R2 first fetch", 32'(rd_log[0]), 32'h20);
        chk("R4 second word", 32'(rd_log[1]), 32'h21);
        chk("R4 next command", 32'(rd_log[2]), 32'h22);
        chk("R9 branch target", 32'(rd_log[4]), 32'h40);
        chk("R5 seek count", 32'(seek_n), 32'd1);
        chk("R5 seek fields", seek_fields, 32'h0123_4567);
        chk("R5 dev_sel", 32'(dev_sel), 32'h5C);
        chk("R7 tx count", 32'(tx_n), 32'd3);
        for (int j = 0; j < 3; j++) chk("R7 tx word", tx_log[j], mem[8'h90 + j]);
        do_tio(st);
        chk("R9 skipped word", 32'(st), 32'hA);

        // Progress interrupt, rejected start, acknowledge (R11 R3 R13)
        mem[8'h50] = cmd_a(4'd2, 1'b1, 16'd4);
        mem[8'h51] = 32'h0000_00A0;
        mem[8'h52] = cmd_a(4'd1, 1'b0, 16'd0);
        mem[8'h53] = 32'h0009_0807;
        mem[8'h54] = cmd_a(4'd0, 1'b0, 16'd0);
        seek_hold = 1'b1;
        seek_n = 0;
        rd_n = 0;
        base = rx_idx;
        do_sio(16'h0050, 8'h22, ok, rej);
        wait_irq();
        repeat (4) @(negedge clk);
        chk("R11 irq mid program", 32'(irq), 32'd1);
        do_tio(st);
        chk("R11 status busy+irq", 32'(st), 32'h9);
        chk("R13 irq cleared", 32'(irq), 32'd0);
        do_sio(16'h0020, 8'h33, ok, rej);
        chk("R3 rejected", 32'(rej), 32'd1);
        chk("R3 not accepted", 32'(ok), 32'd0);
        seek_hold = 1'b0;
        wait_irq();
        do_tio(st);
        chk("R10 status", 32'(st), 32'hA);
        chk("R3 program kept", mem[8'hA0], 32'hA500_0000 + 32'(base));
        chk("R3 seek done once", 32'(seek_n), 32'd1);
        chk("R3 dev unchanged", 32'(dev_sel), 32'h22);
        found = 1'b0;
        for (int j = 0; j < 64 && j < rd_n; j++) if (rd_log[j] == 16'h20) found = 1'b1;
        chk("R3 no fetch of rejected", 32'(found), 32'd0);
        do_tio(st);
        chk("R13 ack persists", 32'(st), 32'h2);

        // Illegal opcode and reserved bits (R12), recovery (R2)
        mem[8'h60] = cmd_a(4'd9, 1'b0, 16'd0);
        do_sio(16'h0060, 8'h01, ok, rej);
        wait_irq();
        do_tio(st);
        chk("R12 bad opcode", 32'(st), 32'hE);
        mem[8'h64] = 32'h0001_0000;
        do_sio(16'h0064, 8'h01, ok, rej);
        wait_irq();
        do_tio(st);
        chk("R12 reserved bits", 32'(st), 32'hE);
        mem[8'h70] = cmd_a(4'd0, 1'b0, 16'd0);
        do_sio(16'h0070, 8'h01, ok, rej);
        wait_irq();
        do_tio(st);
        chk("R2 error cleared", 32'(st), 32'hA);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule